// File: doc/BRIEF.md
# Parallel Display Bus Master (8080-style, 16/8/4-bit)

This block turns single-word host requests into accesses on an 8080-style parallel display bus. All of its logic runs on one LCD clock. A host request carries a read/write flag, a register-select bit and a 16-bit write word. Each accepted request becomes one, two or four bus accesses, depending on the bus width the `mode` input selects when the request is accepted. When the last access of the word has finished, the block returns the read word together with a one-cycle done pulse.

Every bus access follows a fixed schedule of five LCD clocks:

- one setup clock, with chip select and register select already valid;
- two clocks with the write or read strobe asserted;
- two hold clocks, with chip select, register select and any write data still held.

In the narrow modes, data moves on the top lanes of the bus, most significant part first. The bus has a separate output value, a per-lane output enable and an input lane vector, so the pad ring can build the bidirectional pins.

Top module: `lcd8080_master`

## Requirements
- R1: While reset is held and after it is released, the outputs are idle: `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are 1, `lcd_rs` is 0, `lcd_doe` and `lcd_dout` are 0, `req_ready` is 1 and `rsp_done` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the cycle after acceptance until the word completes. Requests presented while `req_ready` is 0 have no effect on the bus.
- R3: Each access lasts 5 clocks. `lcd_cs_n` is 0 in all five. The strobe (`lcd_wr_n` for writes, `lcd_rd_n` for reads, both active low) is 0 only in clocks 2 and 3. The other strobe stays at 1.
- R4: On a write, `lcd_doe` and `lcd_dout` are driven for all 5 clocks of every access, so data is valid 1 clock before the strobe falls and is held 2 clocks after it rises. The bus is released in the cycle after the last access.
- R5: `mode` encoding: 0 = 16-bit on lanes [15:0], 1 = 8-bit on lanes [15:8], 2 = 4-bit on lanes [15:12], 3 = same as 0. Unused lanes have `lcd_doe` = 0 and `lcd_dout` = 0.
- R6: In 8-bit mode a word takes 2 back-to-back accesses, high byte first. In 4-bit mode it takes 4 accesses, bits [15:12] first and bits [3:0] last.
- R7: On a read, `lcd_doe` is 0 throughout. `lcd_din` is sampled in the third clock of each access, which is the last strobe clock. The samples are packed most significant part first into `rsp_rdata`, in the same order as writes.
- R8: `rsp_done` is 1 for exactly one clock, in the cycle right after the final access. `rsp_rdata` holds the assembled read word in that cycle, and `req_ready` is already 1.
- R9: `lcd_rs` equals the request's register-select bit for every clock of every access of that word. `lcd_cs_n` stays 0 without a gap between the accesses of one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | LCD clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Bus width select, sampled on acceptance |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block idle, able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_rs | input | 1 | Register-select value for the request |
| req_wdata | input | 16 | Host write word |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Assembled read word, valid with `rsp_done` |
| lcd_rs | output | 1 | Bus register select |
| lcd_cs_n | output | 1 | Bus chip select, active low |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_dout | output | 16 | Bus output data |
| lcd_doe | output | 16 | Per-lane output enable |
| lcd_din | input | 16 | Bus input lanes |

## Verification
The bench drives input lanes that change every clock. A design that samples one clock early or late, or on the wrong lanes, therefore returns a different read word. It also covers chained requests, where `req_valid` stays high through the done cycle. A design that cannot accept in that cycle, or that drops chip select between the beats of a narrow word, shows up as a timing mismatch on the bus. Other cases:

- A request with different data held valid while the block is busy catches a design that re-latches its inputs mid-word.
- Words with distinct nibbles in every mode, including the alias mode 3, expose swapped beat order, wrong lane placement or stray drive on unused lanes.

// File: rtl/lcd8080_master.sv
module lcd8080_master #(
  parameter int SETUP_CLKS  = 1,
  parameter int STROBE_CLKS = 2,
  parameter int HOLD_CLKS   = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_rs,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic [15:0] rsp_rdata,
  output logic        lcd_rs,
  output logic        lcd_cs_n,
  output logic        lcd_wr_n,
  output logic        lcd_rd_n,
  output logic [15:0] lcd_dout,
  output logic [15:0] lcd_doe,
  input  logic [15:0] lcd_din
);

  localparam int ACCESS = SETUP_CLKS + STROBE_CLKS + HOLD_CLKS;
  localparam int PW     = $clog2(ACCESS + 1);
  localparam logic [PW-1:0] PH_STB_LO = PW'(SETUP_CLKS);
  localparam logic [PW-1:0] PH_STB_HI = PW'(SETUP_CLKS + STROBE_CLKS);
  localparam logic [PW-1:0] PH_SAMPLE = PW'(SETUP_CLKS + STROBE_CLKS - 1);
  localparam logic [PW-1:0] PH_LAST   = PW'(ACCESS - 1);

  logic          busy, wr_q, rs_q, done_q;
  logic [1:0]    mode_q, beat;
  logic [PW-1:0] ph;
  logic [15:0]   sh, acc;
  logic [15:0]   mask, sh_next, acc_next;
  logic          last_beat, strobe_on, sample, end_ph;

  always_comb begin
    case (mode_q)
      2'd1: begin
        mask      = 16'hFF00;
        sh_next   = {sh[7:0], 8'h00};
        acc_next  = {acc[7:0], lcd_din[15:8]};
        last_beat = (beat == 2'd1);
      end
      2'd2: begin
        mask      = 16'hF000;
        sh_next   = {sh[11:0], 4'h0};
        acc_next  = {acc[11:0], lcd_din[15:12]};
        last_beat = (beat == 2'd3);
      end
      default: begin
        mask      = 16'hFFFF;
        sh_next   = sh;
        acc_next  = lcd_din;
        last_beat = 1'b1;
      end
    endcase
  end

  assign strobe_on = busy && (ph >= PH_STB_LO) && (ph < PH_STB_HI);
  assign sample    = busy && !wr_q && (ph == PH_SAMPLE);
  assign end_ph    = (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_q   <= 1'b0;
      rs_q   <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 2'd0;
      beat   <= 2'd0;
      ph     <= '0;
      sh     <= 16'h0;
      acc    <= 16'h0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (req_valid) begin
          busy   <= 1'b1;
          wr_q   <= req_write;
          rs_q   <= req_rs;
          mode_q <= mode;
          beat   <= 2'd0;
          ph     <= '0;
          sh     <= req_wdata;
          acc    <= 16'h0;
        end
      end else begin
        if (sample) acc <= acc_next;
        if (end_ph) begin
          ph <= '0;
          if (last_beat) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end else begin
            beat <= beat + 2'd1;
            sh   <= sh_next;
          end
        end else begin
          ph <= ph + PW'(1);
        end
      end
    end
  end

  assign req_ready = !busy;
  assign rsp_done  = done_q;
  assign rsp_rdata = acc;
  assign lcd_cs_n  = !busy;
  assign lcd_rs    = busy && rs_q;
  assign lcd_wr_n  = !(strobe_on && wr_q);
  assign lcd_rd_n  = !(strobe_on && !wr_q);
  assign lcd_doe   = (busy && wr_q) ? mask : 16'h0;
  assign lcd_dout  = (busy && wr_q) ? (sh & mask) : 16'h0;

  logic [3:0] low_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_len <= 4'd0;
    else if (!lcd_wr_n || !lcd_rd_n) low_len <= low_len + 4'd1;
    else low_len <= 4'd0;
  end

  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  // R3
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lcd_wr_n) || $fell(lcd_rd_n)) |-> $past(!lcd_cs_n));
  // R3
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_wr_n) || $rose(lcd_rd_n)) |-> low_len == 4'(STROBE_CLKS));
  // R3
  hold_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_wr_n) || $rose(lcd_rd_n)) |=> !lcd_cs_n);
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_wr_n) |-> (lcd_doe != 16'h0) && $stable(lcd_dout));
  // R7
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rd_n |-> lcd_doe == 16'h0);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R8
  done_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(!lcd_cs_n) && req_ready);
  // R9
  rs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_rs));

endmodule

// File: tb/lcd8080_master_tb.sv
module lcd8080_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_rs = 1'b0;
  logic [15:0] req_wdata = 16'h0;
  logic        req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic        lcd_rs, lcd_cs_n, lcd_wr_n, lcd_rd_n;
  logic [15:0] lcd_dout, lcd_doe;
  logic [15:0] lcd_din = 16'h0;

  always #2 clk = ~clk;

  lcd8080_master u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_rs(req_rs), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .lcd_rs(lcd_rs), .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_dout(lcd_dout), .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  int checks = 0, failures = 0, cyc = 0;
  logic [37:0] exp_q[$];
  logic [15:0] rd_q[$];
  localparam logic [37:0] IDLE = {1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0, 16'h0};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] din_at(int c);
    return 16'((c * 40503) ^ 16'h5A3C);
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s cycle %0d actual=%h expected=%h", tag, what, cyc, act, exp);
    end
  endtask

  // push the expected per-cycle bus picture of one accepted request
  task automatic predict(logic [1:0] m, logic w, logic r, logic [15:0] d, int k);
    int width = (m == 2'd1) ? 8 : (m == 2'd2) ? 4 : 16;
    int beats = 16 / width;
    logic [15:0] lmask = 16'((32'hFFFF << (16 - width)) & 32'hFFFF);
    logic [15:0] rword = 16'h0;
    for (int b = 0; b < beats; b++) begin
      int shf = 16 - width * (b + 1);
      logic [15:0] chunk = 16'((32'(d) >> shf) & ((32'h1 << width) - 1));
      logic [15:0] smp = 16'(32'(din_at(k + 3 + 5 * b)) >> (16 - width));
      rword = rword | 16'(32'(smp) << shf);
      for (int p = 0; p < 5; p++) begin
        logic stb = (p == 1 || p == 2);
        exp_q.push_back({1'b0, !(stb && w), !(stb && !w), r, 1'b0, 1'b0,
                         w ? lmask : 16'h0, w ? 16'(32'(chunk) << (16 - width)) : 16'h0});
        rd_q.push_back(16'h0);
      end
    end
    exp_q.push_back({1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, 16'h0});
    rd_q.push_back(w ? 16'hxxxx : rword);
  endtask

  // reference model, compared every clock away from the active edge
  always @(negedge clk) begin
    #1;
    lcd_din = din_at(cyc);
    if (rst_n) begin
      logic [37:0] e;
      logic [15:0] er;
      if (exp_q.size() > 0) begin e = exp_q.pop_front(); er = rd_q.pop_front(); end
      else begin e = IDLE; er = 16'hxxxx; end
      checks++;
      chk("R3", "cs_n",  {15'h0, lcd_cs_n}, {15'h0, e[37]});
      chk("R3", "wr_n",  {15'h0, lcd_wr_n}, {15'h0, e[36]});
      chk("R7", "rd_n",  {15'h0, lcd_rd_n}, {15'h0, e[35]});
      chk("R9", "rs",    {15'h0, lcd_rs},   {15'h0, e[34]});
      chk("R2", "ready", {15'h0, req_ready},{15'h0, e[33]});
      chk("R8", "done",  {15'h0, rsp_done}, {15'h0, e[32]});
      chk("R5", "doe",   lcd_doe,  e[31:16]);
      chk((mode == 2'd0) ? "R4" : "R6", "dout", lcd_dout, e[15:0]);
      if (e[32] && !$isunknown(er)) begin
        checks++;
        chk("R7", "rdata", rsp_rdata, er);
      end
      if (req_valid && req_ready) predict(mode, req_write, req_rs, req_wdata, cyc);
    end
  end

  task automatic send(logic [1:0] m, logic w, logic r, logic [15:0] d, bit keep = 0);
    @(negedge clk);
    mode = m; req_write = w; req_rs = r; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (!keep) begin @(negedge clk); req_valid = 1'b0; end
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++; // R1 outputs idle in reset
    chk("R1", "reset bus", {lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_rs, req_ready, rsp_done, lcd_doe == 0, lcd_dout == 0, 8'h0},
        {8'b1110_1011, 8'h0});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    send(2'd0, 1'b1, 1'b1, 16'hA5C3); settle();   // R4 16-bit write
    send(2'd1, 1'b1, 1'b0, 16'h1E2D); settle();   // R6 byte order
    send(2'd2, 1'b1, 1'b1, 16'h4B7F); settle();   // R6 nibble order
    send(2'd3, 1'b1, 1'b0, 16'hC0DE); settle();   // R5 alias mode
    send(2'd0, 1'b0, 1'b1, 16'h0000); settle();   // R7 16-bit read
    send(2'd1, 1'b0, 1'b0, 16'hFFFF); settle();   // R7 8-bit read
    send(2'd2, 1'b0, 1'b1, 16'h1234); settle();   // R7 4-bit read
    // R2 request held with other data while busy must be ignored
    send(2'd1, 1'b1, 1'b1, 16'h55AA, 1);
    @(negedge clk); req_wdata = 16'h9999; req_write = 1'b0; mode = 2'd2;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    settle();
    // R8 chained requests accepted in the done cycle
    send(2'd2, 1'b1, 1'b0, 16'h8421, 1);
    while (!rsp_done) @(negedge clk);
    mode = 2'd0; req_write = 1'b0; req_rs = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    settle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule